// File: doc/BRIEF.md
# Multi-Function Pin Multiplexer Bank

This block is one bank of I/O pin cells. Each pin in the bank hands its pad to exactly one of several sources. Source 0 is the plain GPIO lane, and the other sources are peripheral functions. Every source has its own output value, output enable and input line. A small register file, one word per pin, holds the following for each pin:

- the source select;
- a pull-up enable;
- a pull-down enable;
- an open-drain flag.

The open-drain flag changes the output driver from push-pull to open-drain while the block runs, with no reset needed.

On the pad side each pin drives an output value, an output enable and the two pull enables, and it receives the pad input. The pad input goes to the selected source. Every unselected source sees a fixed idle level. Several banks can sit side by side, and the bank width and the number of ways are both parameters.

Top module: `pin_bank_mux`

## Requirements
- R1: After reset every pin word reads 0. That means source 0 (GPIO), push-pull, both pulls off. Pad outputs then follow source 0, so with source 0 disabled the pad output enable is 0.
- R2: A write to word index `cfg_addr` (0 to NPINS-1) lands on the next clock edge. The word layout is: select in bits [2:0], pull-up in bit 4, pull-down in bit 5, open-drain in bit 6. A read is combinational and returns exactly those bits, with every other bit reading 0.
- R3: In push-pull mode (bit 6 = 0) with a select below NWAYS, `pad_out` equals the selected source's output and `pad_oe` equals its output enable.
- R4: In open-drain mode (bit 6 = 1) `pad_out` is 0, and `pad_oe` is 1 only when the selected source is enabled and drives 0.
- R5: Changing the open-drain bit at run time changes the driver behaviour on the next edge, with no reset.
- R6: `pad_pu` equals the pull-up bit. `pad_pd` equals the pull-down bit with the pull-up bit clear, so both pulls set gives pull-up only.
- R7: The pad input reaches the input of the selected source, at flat index pin*NWAYS+select. Every other source input of that pin sits at IDLE (default 1).
- R8: A select value of NWAYS or above disables the output (`pad_oe` = 0, `pad_out` = 0) and holds every source input of that pin at IDLE.
- R9: A write to an index of NPINS or above changes nothing, and a read of such an index returns 0. A write to one pin leaves every other pin's word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NPINS)+1 | Pin word index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| fn_out | input | NPINS*NWAYS | Source output values, index pin*NWAYS+way |
| fn_oe | input | NPINS*NWAYS | Source output enables, same indexing |
| fn_in | output | NPINS*NWAYS | Source inputs, same indexing |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_pu | output | NPINS | Pad pull-up enable |
| pad_pd | output | NPINS | Pad pull-down enable |
| pad_in | input | NPINS | Pad input value |

## Verification
Two functions can meet in one pin in the same cycle:

- the open-drain conversion of the driver;
- the pull arbitration.

A third coincidence is an out-of-range select that disables the output and idles the inputs while the pull bits stay active. The bench sweeps every select value (including the invalid ones), both driver modes and all four pull combinations, with each pin given a rotated configuration. It then applies eight rotated source patterns and pad-input values. For every pin it computes the expected pad signals and source inputs from the requirements and compares them in the settled half of the cycle.

// File: rtl/pin_bank_mux.sv
module pin_bank_mux #(
  parameter int NPINS = 4,
  parameter int NWAYS = 4,
  parameter bit IDLE  = 1'b1,
  localparam int AW   = $clog2(NPINS) + 1,
  localparam int FW   = NPINS * NWAYS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [FW-1:0] fn_out,
  input  logic [FW-1:0] fn_oe,
  output logic [FW-1:0] fn_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd,
  input  logic [NPINS-1:0] pad_in
);

  logic [2:0]         sel_q [NPINS];
  logic [NPINS-1:0]   pu_q, pd_q, od_q;
  logic [3*NPINS-1:0] sel_flat;
  logic               unused_wbits;

  assign unused_wbits = ^{cfg_wdata[31:7], cfg_wdata[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) sel_q[p] <= 3'd0;
      pu_q <= '0;
      pd_q <= '0;
      od_q <= '0;
    end else if (cfg_we) begin
      for (int p = 0; p < NPINS; p++) begin
        if (cfg_addr == AW'(p)) begin
          sel_q[p] <= cfg_wdata[2:0];
          pu_q[p]  <= cfg_wdata[4];
          pd_q[p]  <= cfg_wdata[5];
          od_q[p]  <= cfg_wdata[6];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < NPINS; p++)
      if (cfg_addr == AW'(p))
        cfg_rdata = {25'd0, od_q[p], pd_q[p], pu_q[p], 1'b0, sel_q[p]};
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic src_out, src_oe;

    assign sel_flat[3*p +: 3] = sel_q[p];

    always_comb begin
      src_out = 1'b0;
      src_oe  = 1'b0;
      for (int w = 0; w < NWAYS; w++) begin
        if (sel_q[p] == 3'(w)) begin
          src_out = fn_out[p*NWAYS + w];
          src_oe  = fn_oe[p*NWAYS + w];
        end
      end
    end

    assign pad_out[p] = ~od_q[p] & src_out;
    assign pad_oe[p]  = od_q[p] ? (src_oe & ~src_out) : src_oe;
    assign pad_pu[p]  = pu_q[p];
    assign pad_pd[p]  = pd_q[p] & ~pu_q[p];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      assign fn_in[p*NWAYS + w] = (sel_q[p] == 3'(w)) ? pad_in[p] : IDLE;
    end
  end

endmodule

// File: rtl/pin_bank_mux_chk.sv
module pin_bank_mux_chk #(
  parameter int NPINS = 4,
  parameter int NWAYS = 4,
  parameter bit IDLE  = 1'b1,
  localparam int AW   = $clog2(NPINS) + 1,
  localparam int FW   = NPINS * NWAYS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [AW-1:0]      cfg_addr,
  input logic [31:0]        cfg_wdata,
  input logic [3*NPINS-1:0] sel_flat,
  input logic [NPINS-1:0]   od_q,
  input logic [FW-1:0]      fn_in,
  input logic [NPINS-1:0]   pad_out,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   pad_pu,
  input logic [NPINS-1:0]   pad_pd
);

  for (genvar p = 0; p < NPINS; p++) begin : g_chk
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == AW'(p)) |=>
        (sel_flat[3*p +: 3] == $past(cfg_wdata[2:0]) && od_q[p] == $past(cfg_wdata[6])));

    p_hold_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr == AW'(p)) |=> ($stable(sel_flat[3*p +: 3]) && $stable(od_q[p])));

    p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      od_q[p] |-> !pad_out[p]);

    p_pull_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pad_pu[p] && pad_pd[p]));

    p_bad_sel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_flat[3*p +: 3] >= 3'(NWAYS) && NWAYS < 8) |->
        (!pad_oe[p] && !pad_out[p] && fn_in[p*NWAYS +: NWAYS] == {NWAYS{IDLE}}));

    p_one_live_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fn_in[p*NWAYS +: NWAYS] ^ {NWAYS{IDLE}}) <= 1);
  end

endmodule

bind pin_bank_mux pin_bank_mux_chk #(.NPINS(NPINS), .NWAYS(NWAYS), .IDLE(IDLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .sel_flat(sel_flat), .od_q(od_q), .fn_in(fn_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/tb_pin_bank_mux.sv
`timescale 1ns/1ps
module tb_pin_bank_mux;
  localparam int NP = 4, NW = 4, AW = 3, FW = NP*NW;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [FW-1:0] fn_out = '0, fn_oe = '0, fn_in;
  logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_in = '0;
  int checks = 0, failures = 0;
  bit done = 0;
  int c_sel [NP];
  bit c_od [NP], c_pu [NP], c_pd [NP];

  always #10 clk = ~clk;

  pin_bank_mux #(.NPINS(NP), .NWAYS(NW)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    cfg_addr = AW'(a); #1 d = cfg_rdata;
  endtask

  function automatic logic [31:0] word(int s, bit pu, bit pd, bit od);
    return {25'd0, od, pd, pu, 1'b0, 3'(s)};
  endfunction

  function automatic logic [15:0] rot(logic [15:0] v, int n);
    return (v << (n % 16)) | (v >> ((16 - n % 16) % 16));
  endfunction

  task automatic set_pin(int p, int s, bit pu, bit pd, bit od);
    c_sel[p] = s; c_pu[p] = pu; c_pd[p] = pd; c_od[p] = od;
    wr(p, word(s, pu, pd, od) | 32'hDEAD_BE88);
  endtask

  task automatic check_pins();
    for (int p = 0; p < NP; p++) begin
      bit v, so, se;
      logic [NW-1:0] ein;
      v = c_sel[p] < NW;
      so = v ? fn_out[p*NW + c_sel[p]] : 1'b0;
      se = v ? fn_oe[p*NW + c_sel[p]] : 1'b0;
      ein = '1;
      if (v) ein[c_sel[p]] = pad_in[p];
      if (!v)
        chk("R8 out/oe", {pad_out[p], pad_oe[p]}, 2'b00);
      else if (c_od[p])
        chk("R4 out/oe", {pad_out[p], pad_oe[p]}, {1'b0, se & ~so});
      else
        chk("R3 out/oe", {pad_out[p], pad_oe[p]}, {so, se});
      chk("R6 pulls", {pad_pu[p], pad_pd[p]}, {c_pu[p], c_pd[p] & ~c_pu[p]});
      chk(v ? "R7 fn_in" : "R8 fn_in", fn_in[p*NW +: NW], ein);
    end
  endtask

  initial begin
    #(20*200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin c_sel[p] = 0; c_pu[p] = 0; c_pd[p] = 0; c_od[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    fn_oe = 16'h0000; fn_out = 16'hFFFF; #1;
    for (int p = 0; p < NP; p++) begin rd(p, d); chk("R1 reset word", d, 0); end
    chk("R1 reset pads", {pad_oe, pad_pu, pad_pd}, 0);
    fn_oe = 16'h1111; fn_out = 16'h0101; #1;
    chk("R1 gpio push-pull", {pad_oe, pad_out}, {4'hF, 4'b0101});

    // R9 out of range index
    for (int a = NP; a < 8; a++) begin
      wr(a, 32'h7F);
      rd(a, d); chk("R9 oob read", d, 0);
    end
    for (int p = 0; p < NP; p++) begin rd(p, d); chk("R9 oob no effect", d, 0); end

    // R2 field mask and R9 isolation
    set_pin(2, 5, 1, 0, 1);
    rd(2, d); chk("R2 readback masked", d, 32'h55);
    for (int p = 0; p < NP; p++) if (p != 2) begin rd(p, d); chk("R9 others untouched", d, 0); end

    // R5 run-time mode switch
    set_pin(0, 1, 0, 0, 0);
    fn_out = 16'h0002; fn_oe = 16'h0002; #1;
    chk("R5 pp drives 1", {pad_out[0], pad_oe[0]}, 2'b11);
    set_pin(0, 1, 0, 0, 1); #1;
    chk("R5 od releases 1", {pad_out[0], pad_oe[0]}, 2'b00);
    fn_out = 16'h0000; #1;
    chk("R5 od sinks 0", {pad_out[0], pad_oe[0]}, 2'b01);
    set_pin(0, 1, 0, 0, 0); #1;
    chk("R5 back to pp", {pad_out[0], pad_oe[0]}, 2'b01);

    // sweep
    for (int s = 0; s < 8; s++)
      for (int od = 0; od < 2; od++)
        for (int pl = 0; pl < 4; pl++) begin
          for (int p = 0; p < NP; p++) begin
            int q;
            q = (pl + p) % 4;
            set_pin(p, (s + p) % 8, q[0], q[1], bit'(od ^ (p & 1)));
          end
          for (int p = 0; p < NP; p++) begin
            rd(p, d); chk("R2 sweep readback", d, word(c_sel[p], c_pu[p], c_pd[p], c_od[p]));
          end
          for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            fn_out = rot(16'hA5C3, k);
            fn_oe  = rot(16'h3C96, 3*k);
            pad_in = 4'(k*5);
            #2 check_pins();
          end
        end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule